// File: doc/BRIEF.md
# Three-Wire Panel Register Writer

This block is a serial master that programs one 16-bit register of a display driver over a three-wire bus. The bus has an active-low select line, a clock line and a data line. A host pulses `start` with a register number and a value. The block then sends two framed transfers back to back. The first transfer carries the register number and the second carries the value. A long deselect gap separates them. `busy` covers the whole transaction, and a one-cycle `done` marks its end.

Each transfer is 24 bits, sent most significant bit first. It holds a fixed 6-bit device code, then a frame-kind bit, then a write bit, then the 16-bit payload. Timing is set by a bit-phase parameter counted in system clocks. Each clock half-period lasts one phase. One phase also separates the select falling and the first clock edge. The deselect gap lasts ten phases, and one phase trails the end of the second frame.

Top module: `panel_serial_writer`

## Requirements
- R1: After reset and whenever `busy` is low, `pnl_en_n`, `pnl_sclk` and `pnl_sdo` are all 1, and `done` is 0.
- R2: A `start` seen while idle raises `busy` and lowers `pnl_en_n` at the same clock edge. `busy` stays high until `done` pulses for exactly one cycle, and `busy` falls at that same edge.
- R3: After `pnl_en_n` falls, the first falling edge of `pnl_sclk` comes exactly PHASE_CYCLES clocks later.
- R4: Inside a frame, `pnl_sdo` changes only where `pnl_sclk` falls. Clock low and clock high each last PHASE_CYCLES clocks. Each frame has exactly 24 rising clock edges.
- R5: A frame, read MSB first at the rising clock edges, is {device code 6'h1D, kind bit, write bit 0, 16-bit payload}. The kind bit is 0 for the index frame and 1 for the data frame.
- R6: The first frame's payload is `reg_addr` and the second frame's payload is `reg_data`.
- R7: Between the frames, `pnl_en_n` is high for exactly 10*PHASE_CYCLES clocks, with `pnl_sdo` and `pnl_sclk` both high.
- R8: After the last data-frame bit, `pnl_en_n` rises. `done` follows one phase later, which is 109*PHASE_CYCLES clocks after the accepting edge.
- R9: A `start` arriving while `busy` is high is ignored: exactly two frames are sent, and their contents are unchanged.
- R10: `reg_addr` and `reg_data` are captured on the accepting edge. Later changes to them do not alter the frames being sent.
- R11: A synchronous `rst` during a transaction returns the outputs to the R1 state, and the next write proceeds normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one register write |
| reg_addr | input | PAY_W | Register number for the index frame |
| reg_data | input | PAY_W | Value for the data frame |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| pnl_en_n | output | 1 | Bus select, active low |
| pnl_sclk | output | 1 | Bus clock, idles high |
| pnl_sdo | output | 1 | Bus data, idles high |

## Verification
The in-line properties assume that `start` is a clean synchronous level. They also assume that `rst`, once raised, is held for at least one full clock so that all outputs settle to idle. The stimulus always changes inputs on the falling clock edge. It holds reset for two or more cycles and issues `start` both from idle and while busy. The ignored-start case is therefore exercised rather than assumed away. Payloads are chosen so that all-ones, all-zeros and alternating patterns pass through both frame kinds.

// File: rtl/panel_ser_pkg.sv
`timescale 1ns/1ps
package panel_ser_pkg;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_LEAD,
      PS_BLO,
      PS_BHI,
      PS_GAP,
      PS_TAIL
   } psw_state_e;

   typedef enum logic {
      FK_INDEX = 1'b0,
      FK_DATA  = 1'b1
   } psw_kind_e;

endpackage

// File: rtl/psw_phase_timer.sv
`timescale 1ns/1ps
module psw_phase_timer #(
   parameter int PHASE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic tick
);
   localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PHASE_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (restart)      cnt <= RELOAD;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign tick = (cnt == '0);

   AST_RELOAD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
      (restart && (PHASE_CYCLES > 1)) |=> !tick) else $error("early tick"); // R4
endmodule

// File: rtl/psw_frame_shifter.sv
`timescale 1ns/1ps
module psw_frame_shifter #(
   parameter int              ID_W   = 6,
   parameter logic [ID_W-1:0] DEV_ID = 6'h1D,
   parameter int              PAY_W  = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             load_kind,
   input  logic [PAY_W-1:0] load_payload,
   input  logic             shift,
   output logic             msb
);
   localparam int FRAME_W = ID_W + 2 + PAY_W;

   logic [FRAME_W-1:0] sr;

   always_ff @(posedge clk) begin
      if (rst)        sr <= '1;
      else if (load)  sr <= {DEV_ID, load_kind, 1'b0, load_payload};
      else if (shift) sr <= {sr[FRAME_W-2:0], 1'b1};
   end

   assign msb = sr[FRAME_W-1];

   AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(load && shift)) else $error("load and shift together"); // R5
endmodule

// File: rtl/panel_serial_writer.sv
`timescale 1ns/1ps
module panel_serial_writer
   import panel_ser_pkg::*;
#(
   parameter int              PHASE_CYCLES = 4,
   parameter int              GAP_PHASES   = 10,
   parameter int              ID_W         = 6,
   parameter logic [ID_W-1:0] DEV_ID       = 6'h1D,
   parameter int              PAY_W        = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [PAY_W-1:0] reg_addr,
   input  logic [PAY_W-1:0] reg_data,
   output logic             busy,
   output logic             done,
   output logic             pnl_en_n,
   output logic             pnl_sclk,
   output logic             pnl_sdo
);
   localparam int FRAME_W = ID_W + 2 + PAY_W;
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam int GAP_W   = (GAP_PHASES > 1) ? $clog2(GAP_PHASES) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(FRAME_W - 1);
   localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(GAP_PHASES - 1);

   generate
      if (PHASE_CYCLES < 1) begin : g_bad_phase
         $error("PHASE_CYCLES must be at least 1");
      end
      if (GAP_PHASES < 1) begin : g_bad_gap
         $error("GAP_PHASES must be at least 1");
      end
      if (PAY_W < 1 || ID_W < 1) begin : g_bad_width
         $error("frame field widths must be positive");
      end
   endgenerate

   psw_state_e       state;
   psw_kind_e        kind;
   logic [BIT_W-1:0] bit_left;
   logic [GAP_W-1:0] gap_left;
   logic [PAY_W-1:0] data_q;

   logic tick, adv, accept, restart;
   logic sh_load, sh_shift, sh_msb, sh_kind;
   logic [PAY_W-1:0] sh_pay;

   assign accept  = (state == PS_IDLE) && start;
   assign adv     = (state != PS_IDLE) && tick;
   assign restart = accept || adv;

   assign sh_load  = accept || ((state == PS_GAP) && tick && (gap_left == '0));
   assign sh_kind  = (state == PS_GAP);
   assign sh_pay   = (state == PS_GAP) ? data_q : reg_addr;
   assign sh_shift = adv && ((state == PS_LEAD) ||
                             ((state == PS_BHI) && (bit_left != '0)));

   psw_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .tick    (tick)
   );

   psw_frame_shifter #(.ID_W(ID_W), .DEV_ID(DEV_ID), .PAY_W(PAY_W)) u_shift (
      .clk          (clk),
      .rst          (rst),
      .load         (sh_load),
      .load_kind    (sh_kind),
      .load_payload (sh_pay),
      .shift        (sh_shift),
      .msb          (sh_msb)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= PS_IDLE;
         kind     <= FK_INDEX;
         bit_left <= '0;
         gap_left <= '0;
         data_q   <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         pnl_en_n <= 1'b1;
         pnl_sclk <= 1'b1;
         pnl_sdo  <= 1'b1;
      end else begin
         done <= 1'b0;
         case (state)
            PS_IDLE: begin
               if (start) begin
                  state    <= PS_LEAD;
                  kind     <= FK_INDEX;
                  data_q   <= reg_data;
                  busy     <= 1'b1;
                  pnl_en_n <= 1'b0;
               end
            end
            PS_LEAD: begin
               if (tick) begin
                  state    <= PS_BLO;
                  bit_left <= LAST_BIT;
                  pnl_sclk <= 1'b0;
                  pnl_sdo  <= sh_msb;
               end
            end
            PS_BLO: begin
               if (tick) begin
                  state    <= PS_BHI;
                  pnl_sclk <= 1'b1;
               end
            end
            PS_BHI: begin
               if (tick) begin
                  if (bit_left == '0) begin
                     pnl_en_n <= 1'b1;
                     pnl_sdo  <= 1'b1;
                     if (kind == FK_DATA) begin
                        state <= PS_TAIL;
                     end else begin
                        state    <= PS_GAP;
                        gap_left <= GAP_RELOAD;
                     end
                  end else begin
                     state    <= PS_BLO;
                     bit_left <= bit_left - 1'b1;
                     pnl_sclk <= 1'b0;
                     pnl_sdo  <= sh_msb;
                  end
               end
            end
            PS_GAP: begin
               if (tick) begin
                  if (gap_left == '0) begin
                     state    <= PS_LEAD;
                     kind     <= FK_DATA;
                     pnl_en_n <= 1'b0;
                  end else begin
                     gap_left <= gap_left - 1'b1;
                  end
               end
            end
            PS_TAIL: begin
               if (tick) begin
                  state <= PS_IDLE;
                  busy  <= 1'b0;
                  done  <= 1'b1;
               end
            end
            default: state <= PS_IDLE;
         endcase
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (pnl_en_n && pnl_sclk && pnl_sdo)) else $error("idle not high"); // R1
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(busy))) else $error("done without busy end"); // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done) else $error("done too long"); // R2
   AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      (!pnl_en_n && $past(!pnl_en_n) && !$stable(pnl_sdo)) |-> $fell(pnl_sclk))
      else $error("data moved off clock fall"); // R4
   AST_GAP_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
      (busy && pnl_en_n) |-> (pnl_sdo && pnl_sclk)) else $error("gap lines low"); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> $stable(data_q)) else $error("busy start taken"); // R9
endmodule

// File: tb/panel_serial_writer_tb.sv
`timescale 1ns/1ps
module panel_serial_writer_tb;
   localparam int P = 2;
   localparam int NV = 6;
   localparam logic [31:0] VEC [NV] = '{
      {16'h0001, 16'h001D}, {16'h0005, 16'h50A3}, {16'hFFFF, 16'h0000},
      {16'h0000, 16'hFFFF}, {16'hA5A5, 16'h5A5A}, {16'h8001, 16'h7FFE}};

   logic clk = 1'b0, rst = 1'b1, start = 1'b0;
   logic [15:0] reg_addr = '0, reg_data = '0;
   logic busy, done, pnl_en_n, pnl_sclk, pnl_sdo;
   int nchk = 0, nerr = 0;

   always #2 clk = ~clk;

   panel_serial_writer #(.PHASE_CYCLES(P)) u_dut (
      .clk(clk), .rst(rst), .start(start), .reg_addr(reg_addr), .reg_data(reg_data),
      .busy(busy), .done(done), .pnl_en_n(pnl_en_n), .pnl_sclk(pnl_sclk), .pnl_sdo(pnl_sdo));

   // bus monitor
   int nfr = 0, edges = 0, e_base = 0, lead_cur = 0, gap_cur = 0, gap_bad = 0;
   time t_fall = 0, t_rise = 0;
   logic [23:0] cap = '0;
   logic [23:0] fw [64];
   int fe [64], lead_a [64], gap_a [64];

   always @(negedge pnl_en_n) begin
      t_fall = $time; e_base = edges; gap_cur = int'((t_fall - t_rise) / 4);
   end
   always @(negedge pnl_sclk) if (!pnl_en_n && edges == e_base)
      lead_cur = int'(($time - t_fall) / 4);
   always @(posedge pnl_sclk) if (pnl_en_n === 1'b0) begin
      cap = {cap[22:0], pnl_sdo}; edges++;
   end
   always @(posedge pnl_en_n) begin
      t_rise = $time;
      fw[nfr % 64] = cap; fe[nfr % 64] = edges - e_base;
      lead_a[nfr % 64] = lead_cur; gap_a[nfr % 64] = gap_cur;
      nfr++;
   end
   always @(negedge clk) if (!rst && busy && pnl_en_n && !(pnl_sdo && pnl_sclk)) gap_bad++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] frm(input logic kind, input logic [15:0] pay);
      return {6'h1D, kind, 1'b0, pay};
   endfunction

   task automatic chk_idle(input string req);
      chk(req, {29'd0, pnl_en_n, pnl_sclk, pnl_sdo}, 32'h7);
      chk(req, {30'd0, busy, done}, 32'h0);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [15:0] d, input bit perturb);
      int base, bad0, n, lat;
      time t0;
      base = nfr; bad0 = gap_bad; n = 0;
      @(negedge clk); start = 1'b1; reg_addr = a; reg_data = d;
      @(posedge clk); t0 = $time;
      @(negedge clk); start = 1'b0;
      chk("R2 busy/enable on accept", {30'd0, busy, pnl_en_n}, 32'h2);
      if (perturb) begin
         reg_addr = ~a; reg_data = ~d; start = 1'b1;      // R9 R10
         @(negedge clk); start = 1'b0;
      end
      while (!done && n < 2000) begin @(negedge clk); n++; end
      chk("R8 watchdog", {31'd0, done}, 32'h1);
      lat = int'(($time - 2 - t0) / 4);
      chk("R8 latency", lat, 109 * P);
      chk("R2 busy low with done", {31'd0, busy}, 32'h0);
      chk("R9 frame count", nfr - base, 2);
      chk("R5 R6 index frame", fw[base % 64], frm(1'b0, a));
      chk("R5 R6 data frame", fw[(base + 1) % 64], frm(1'b1, d));
      chk("R4 edges index", fe[base % 64], 24);
      chk("R4 edges data", fe[(base + 1) % 64], 24);
      chk("R3 lead index", lead_a[base % 64], P);
      chk("R3 lead data", lead_a[(base + 1) % 64], P);
      chk("R7 gap length", gap_a[(base + 1) % 64], 10 * P);
      chk("R7 gap lines high", gap_bad - bad0, 0);
      @(negedge clk);
      chk_idle("R1 R2 idle after done");
   endtask

   initial begin
      #(4 * 200000);
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R1 reset state");
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk_idle("R1 idle after reset");
      for (int i = 0; i < NV; i++) do_write(VEC[i][31:16], VEC[i][15:0], 1'b0);
      do_write(16'h1234, 16'hC3C3, 1'b1);  // R9 R10
      // R11 reset mid-transaction
      @(negedge clk); start = 1'b1; reg_addr = 16'h00FF; reg_data = 16'hFF00;
      @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk_idle("R11 reset mid-transaction");
      rst = 1'b0;
      @(negedge clk);
      chk_idle("R11 idle after release");
      do_write(16'h0F0F, 16'hF0F0, 1'b0);  // R11 next write normal
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule